// File: doc/BRIEF.md
# Core-Local Timer and Software-Interrupt Controller

This block gives every hart in a cluster two interrupt sources: a software-interrupt line that any agent can raise or clear by writing a register, and a timer-interrupt line. The timer line is driven from a single shared 64-bit time counter and a 64-bit compare value held for each hart. The time counter advances by a programmable step on every cycle in which the tick enable is high. A hart's timer line is high whenever the counter is at or above that hart's compare value.

Software reaches the registers through a simple 32-bit bus. Each request carries an address, write data and byte enables, and it is answered one cycle later with read data and an error flag. The register map is sparse. Software-interrupt words start at 0x0000 with a stride of 4 bytes. Compare registers start at 0x4000 with a stride of 8 bytes, low half first. The time counter's low half is at 0xBFF8 and its high half at 0xBFFC, and the whole window spans 0xC0000 bytes. Any request that is misaligned, or that does not land inside one of the three mapped ranges, is declined.

Top module: `core_timer_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the time counter and every software-interrupt bit read as zero, and every compare register reads as all ones. No interrupt line is high.
- R2: The software-interrupt word of hart h sits at offset 4*h. A read of this word returns the hart's bit in bit 0 and zero in bits 31:1. The hart's soft_irq output equals that bit.
- R3: A write to a software-interrupt word loads bit 0 of the write data only when byte enable 0 is set. When byte enable 0 is clear, the bit is left unchanged. Bits 31:1 of the write data never matter.
- R4: The compare register of hart h has its low word at 0x4000+8*h and its high word at 0x4004+8*h. A write changes only the bytes whose enable bit is set, and byte enable bit k covers data bits 8k+7:8k.
- R5: The time counter's low word is at 0xBFF8 and its high word at 0xBFFC. A write changes only the enabled bytes.
- R6: timer_irq[h] is high exactly when the time counter is greater than or equal to hart h's compare value, compared as unsigned 64-bit numbers.
- R7: A write to a compare register or to the time counter takes effect on the timer lines in the same cycle in which the response is presented.
- R8: In each cycle with tick_en high, the full 64-bit counter grows by tick_step, and a carry passes from the low word into the high word.
- R9: If a time-counter write with at least one byte enabled meets a tick in the same cycle, the written bytes are stored and that cycle's increment is dropped. A write to any other register does not stop the tick.
- R10: A misaligned request, or one outside the three mapped ranges, gets rsp_err high. Its read data is zero and it changes no register.
- R11: Every request is answered exactly one cycle later with rsp_valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Advance the time counter this cycle |
| tick_step | input | STEP_W | Amount added per tick |
| req_valid | input | 1 | Bus request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address within the window |
| req_wdata | input | 32 | Write data |
| req_strb | input | 4 | Byte enables for the write |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data, zero for writes and errors |
| rsp_err | output | 1 | Request declined |
| timer_irq | output | NUM_HARTS | Per-hart timer interrupt |
| soft_irq | output | NUM_HARTS | Per-hart software interrupt |

## Verification
The bench drives a register write and a counter tick in the same cycle. It does this once against each half of the time counter and once against a compare register. A write to the counter must store the written value with no increment added. A write to a compare register must leave the tick in place, so the counter gains exactly one step. The bench predicts both outcomes from its own 64-bit model and compares them with word reads taken after the tick is removed. The same cycle is also checked on the timer lines, which must reflect the new compare value together with the advanced counter.

// File: rtl/ctl_pkg.sv
// Package: shared constants, region codes and the byte-merge helper for the
// core-local timer controller. Assumes a 32-bit data bus with 4 byte enables.
package ctl_pkg;

    localparam int unsigned SOFT_BASE = 32'h0000_0000;
    localparam int unsigned CMP_BASE  = 32'h0000_4000;
    localparam int unsigned TIME_BASE = 32'h0000_BFF8;
    localparam int unsigned WIN_SPAN  = 32'h000C_0000;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_SOFT = 2'd1,
        RG_CMP  = 2'd2,
        RG_TIME = 2'd3
    } region_e;

    // Replace the enabled bytes of old_w with those of new_w.
    function automatic logic [31:0] byte_merge(input logic [31:0] old_w,
                                               input logic [31:0] new_w,
                                               input logic [3:0]  strb);
        logic [31:0] res;
        res = old_w;
        for (int b = 0; b < 4; b++) begin
            if (strb[b]) res[8*b +: 8] = new_w[8*b +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/ctl_decode.sv
// Address decoder: classifies a byte address into one of the three mapped
// ranges, or none. Assumes word-aligned 32-bit accesses. A misaligned
// address, or one outside every range, yields RG_NONE.
module ctl_decode
    import ctl_pkg::*;
#(
    parameter int NUM_HARTS = 2,
    parameter int ADDR_W    = 20,
    parameter int IDX_W     = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [IDX_W-1:0]  idx,
    output logic              hi_half
);

    localparam logic [ADDR_W-1:0] SOFT_END = ADDR_W'(SOFT_BASE + 4 * NUM_HARTS);
    localparam logic [ADDR_W-1:0] CMP_LO   = ADDR_W'(CMP_BASE);
    localparam logic [ADDR_W-1:0] CMP_END  = ADDR_W'(CMP_BASE + 8 * NUM_HARTS);
    localparam logic [ADDR_W-1:0] TIME_LO  = ADDR_W'(TIME_BASE);
    localparam logic [ADDR_W-1:0] TIME_END = ADDR_W'(TIME_BASE + 8);

    logic aligned;

    // Range match; the bases are 8-byte aligned, so bit 2 selects the upper word.
    always_comb begin
        region  = RG_NONE;
        idx     = '0;
        hi_half = 1'b0;
        aligned = (addr[1:0] == 2'b00);
        if (aligned) begin
            if (addr < SOFT_END) begin
                region = RG_SOFT;
                idx    = IDX_W'(addr >> 2);
            end else if (addr >= CMP_LO && addr < CMP_END) begin
                region  = RG_CMP;
                idx     = IDX_W'((addr - CMP_LO) >> 3);
                hi_half = addr[2];
            end else if (addr >= TIME_LO && addr < TIME_END) begin
                region  = RG_TIME;
                hi_half = addr[2];
            end
        end
    end

endmodule

// File: rtl/ctl_timebase.sv
// Shared 64-bit time counter. A software write to either word replaces the
// enabled bytes and takes priority over a tick in the same cycle. Otherwise
// the counter adds tick_step on each enabled tick. The caller gates wr_lo and
// wr_hi so that at most one is high.
module ctl_timebase
    import ctl_pkg::*;
#(
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [STEP_W-1:0] tick_step,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [31:0]       wdata,
    input  logic [3:0]        strb,
    output logic [63:0]       time_q
);

    // Counter update: reset, then write, then tick, in that priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q <= '0;
        end else if (wr_lo) begin
            time_q[31:0] <= byte_merge(time_q[31:0], wdata, strb);
        end else if (wr_hi) begin
            time_q[63:32] <= byte_merge(time_q[63:32], wdata, strb);
        end else if (tick_en) begin
            time_q <= time_q + 64'(tick_step);
        end
    end

endmodule

// File: rtl/ctl_hart_slot.sv
// Per-hart state: the 64-bit compare register, the software-interrupt bit and
// the unsigned compare that drives the timer line. The timer line is
// combinational on the registers, so it follows every write and tick.
module ctl_hart_slot
    import ctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [63:0] time_now,
    input  logic        cmp_wr_lo,
    input  logic        cmp_wr_hi,
    input  logic [31:0] wdata,
    input  logic [3:0]  strb,
    input  logic        soft_wr,
    input  logic        soft_byte_en,
    input  logic        soft_bit,
    output logic [63:0] cmp_q,
    output logic        soft_q,
    output logic        timer_irq
);

    // Compare register: resets to all ones, byte-granular writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '1;
        end else if (cmp_wr_lo) begin
            cmp_q[31:0] <= byte_merge(cmp_q[31:0], wdata, strb);
        end else if (cmp_wr_hi) begin
            cmp_q[63:32] <= byte_merge(cmp_q[63:32], wdata, strb);
        end
    end

    // Software bit: loaded only when the lowest byte is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_q <= 1'b0;
        end else if (soft_wr && soft_byte_en) begin
            soft_q <= soft_bit;
        end
    end

    // Level timer line from the unsigned 64-bit compare.
    always_comb begin
        timer_irq = (time_now >= cmp_q);
    end

endmodule

// File: rtl/core_timer_ctrl.sv
// Top: core-local timer and software-interrupt controller. It decodes bus
// requests, routes writes to the time base and the per-hart slots, muxes read
// data and registers a one-cycle response. Assumes ADDR_W is wide enough for
// the 0xC0000-byte window and that requests arrive in the clk domain.
module core_timer_ctrl
    import ctl_pkg::*;
#(
    parameter int NUM_HARTS = 2,
    parameter int ADDR_W    = 20,
    parameter int STEP_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_en,
    input  logic [STEP_W-1:0]    tick_step,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [31:0]          req_wdata,
    input  logic [3:0]           req_strb,
    output logic                 rsp_valid,
    output logic [31:0]          rsp_rdata,
    output logic                 rsp_err,
    output logic [NUM_HARTS-1:0] timer_irq,
    output logic [NUM_HARTS-1:0] soft_irq
);

    localparam int IDX_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

    region_e          dec_region;
    logic [IDX_W-1:0] dec_idx;
    logic             dec_hi;
    logic             acc_ok;
    logic             wr_go;
    logic             time_wr_lo;
    logic             time_wr_hi;
    logic [63:0]      time_q;
    logic [63:0]      cmp_arr [NUM_HARTS];
    logic [31:0]      rd_word;

    ctl_decode #(
        .NUM_HARTS(NUM_HARTS),
        .ADDR_W   (ADDR_W),
        .IDX_W    (IDX_W)
    ) u_decode (
        .addr   (req_addr),
        .region (dec_region),
        .idx    (dec_idx),
        .hi_half(dec_hi)
    );

    // Write qualification: a valid, mapped write request.
    always_comb begin
        acc_ok     = (dec_region != RG_NONE);
        wr_go      = req_valid && req_write && acc_ok;
        time_wr_lo = wr_go && (dec_region == RG_TIME) && !dec_hi && (req_strb != 4'b0000);
        time_wr_hi = wr_go && (dec_region == RG_TIME) &&  dec_hi && (req_strb != 4'b0000);
    end

    ctl_timebase #(
        .STEP_W(STEP_W)
    ) u_timebase (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .tick_step(tick_step),
        .wr_lo    (time_wr_lo),
        .wr_hi    (time_wr_hi),
        .wdata    (req_wdata),
        .strb     (req_strb),
        .time_q   (time_q)
    );

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
        logic sel;
        logic cmp_lo_we;
        logic cmp_hi_we;
        logic soft_we;

        // Per-hart write enables from the decoded index.
        always_comb begin
            sel       = (dec_idx == IDX_W'(h));
            cmp_lo_we = wr_go && (dec_region == RG_CMP) && sel && !dec_hi;
            cmp_hi_we = wr_go && (dec_region == RG_CMP) && sel &&  dec_hi;
            soft_we   = wr_go && (dec_region == RG_SOFT) && sel;
        end

        ctl_hart_slot u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .time_now    (time_q),
            .cmp_wr_lo   (cmp_lo_we),
            .cmp_wr_hi   (cmp_hi_we),
            .wdata       (req_wdata),
            .strb        (req_strb),
            .soft_wr     (soft_we),
            .soft_byte_en(req_strb[0]),
            .soft_bit    (req_wdata[0]),
            .cmp_q       (cmp_arr[h]),
            .soft_q      (soft_irq[h]),
            .timer_irq   (timer_irq[h])
        );
    end

    // Read mux over the three ranges; unmapped reads give zero.
    always_comb begin
        rd_word = '0;
        case (dec_region)
            RG_SOFT: rd_word = {31'b0, soft_irq[dec_idx]};
            RG_CMP:  rd_word = dec_hi ? cmp_arr[dec_idx][63:32] : cmp_arr[dec_idx][31:0];
            RG_TIME: rd_word = dec_hi ? time_q[63:32] : time_q[31:0];
            default: rd_word = '0;
        endcase
    end

    // One-cycle registered response with error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && !acc_ok;
            rsp_rdata <= (req_valid && !req_write && acc_ok) ? rd_word : 32'h0;
        end
    end

endmodule

// File: rtl/ctl_checker.sv
// Checker: temporal properties of the timer controller, attached by bind.
// Assumes the bound scope exposes time_q and the top-level ports.
module ctl_checker
    import ctl_pkg::*;
#(
    parameter int NUM_HARTS = 2,
    parameter int ADDR_W    = 20,
    parameter int STEP_W    = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick_en,
    input logic [STEP_W-1:0]    tick_step,
    input logic                 req_valid,
    input logic                 req_write,
    input logic [ADDR_W-1:0]    req_addr,
    input logic [31:0]          req_wdata,
    input logic [3:0]           req_strb,
    input logic                 rsp_valid,
    input logic [31:0]          rsp_rdata,
    input logic                 rsp_err,
    input logic [63:0]          time_q,
    input logic [NUM_HARTS-1:0] timer_irq,
    input logic [NUM_HARTS-1:0] soft_irq
);

    localparam logic [ADDR_W-1:0] TIME_LO_A = ADDR_W'(TIME_BASE);

    logic soft_rd_q;

    // Remember whether the previous request was a read of a software word.
    always_ff @(posedge clk) begin
        if (!rst_n) soft_rd_q <= 1'b0;
        else        soft_rd_q <= req_valid && !req_write &&
                                 (req_addr < ADDR_W'(4 * NUM_HARTS)) &&
                                 (req_addr[1:0] == 2'b00);
    end

    // R11
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R10
    err_keeps_soft_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (soft_irq == $past(soft_irq)));

    // R2
    soft_read_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err && soft_rd_q) |-> ((rsp_rdata >> 1) == 32'h0));

    // R8
    tick_adds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tick_en) && !$past(req_valid && req_write))
        |-> (time_q == $past(time_q) + 64'($past(tick_step))));

    // R9
    write_beats_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && tick_en && req_valid && req_write &&
              req_addr == TIME_LO_A && req_strb == 4'hF)
        |-> (time_q[31:0] == $past(req_wdata)));

    // R6
    irq_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(req_valid && req_write) && time_q >= $past(time_q))
        |-> ((timer_irq & $past(timer_irq)) == $past(timer_irq)));

endmodule

bind core_timer_ctrl ctl_checker #(
    .NUM_HARTS(NUM_HARTS),
    .ADDR_W   (ADDR_W),
    .STEP_W   (STEP_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .tick_step(tick_step),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .req_strb (req_strb),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata),
    .rsp_err  (rsp_err),
    .time_q   (time_q),
    .timer_irq(timer_irq),
    .soft_irq (soft_irq)
);

// File: tb/core_timer_ctrl_tb_top.sv
`timescale 1ns/1ps
module core_timer_ctrl_tb_top;

    localparam int NH = 2;
    localparam int AW = 20;
    localparam int SW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic [SW-1:0] tick_step = '0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [3:0]    req_strb = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic          rsp_err;
    logic [NH-1:0] timer_irq;
    logic [NH-1:0] soft_irq;

    int n_checks = 0;
    int n_errs = 0;
    bit done = 0;

    logic [63:0] m_time;
    logic [63:0] m_cmp [NH];
    logic [NH-1:0] m_soft;

    always #2.5 clk = ~clk;

    core_timer_ctrl #(.NUM_HARTS(NH), .ADDR_W(AW), .STEP_W(SW)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tick_step(tick_step),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_strb(req_strb), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .timer_irq(timer_irq),
        .soft_irq(soft_irq));

    function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] s);
        logic [31:0] r;
        r = o;
        for (int b = 0; b < 4; b++) if (s[b]) r[8*b +: 8] = n[8*b +: 8];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One bus transaction: drive at a falling edge, sample at the next one.
    task automatic bus(input logic wr, input logic [AW-1:0] a, input logic [31:0] d,
                       input logic [3:0] s, output logic [31:0] rd, output logic er);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_strb = s;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk("R11 rsp_valid", 64'(rsp_valid), 64'd1);
        rd = rsp_rdata;
        er = rsp_err;
    endtask

    function automatic logic [NH-1:0] exp_tirq();
        logic [NH-1:0] r;
        for (int h = 0; h < NH; h++) r[h] = (m_time >= m_cmp[h]);
        return r;
    endfunction

    task automatic check_lines(input string tag);
        chk({tag, " R6 timer_irq"}, 64'(timer_irq), 64'(exp_tirq()));
        chk({tag, " R2 soft_irq"}, 64'(soft_irq), 64'(m_soft));
    endtask

    task automatic check_all(input string tag);
        logic [31:0] rd;
        logic er;
        for (int h = 0; h < NH; h++) begin
            bus(1'b0, AW'(4 * h), 32'h0, 4'h0, rd, er);
            chk({tag, " R2 soft read"}, {32'h0, rd}, {63'h0, m_soft[h]});
            bus(1'b0, AW'(32'h4000 + 8 * h), 32'h0, 4'h0, rd, er);
            chk({tag, " R4 cmp lo"}, {32'h0, rd}, {32'h0, m_cmp[h][31:0]});
            bus(1'b0, AW'(32'h4004 + 8 * h), 32'h0, 4'h0, rd, er);
            chk({tag, " R4 cmp hi"}, {32'h0, rd}, {32'h0, m_cmp[h][63:32]});
        end
        bus(1'b0, 20'h0BFF8, 32'h0, 4'h0, rd, er);
        chk({tag, " R5 time lo"}, {32'h0, rd}, {32'h0, m_time[31:0]});
        bus(1'b0, 20'h0BFFC, 32'h0, 4'h0, rd, er);
        chk({tag, " R5 time hi"}, {32'h0, rd}, {32'h0, m_time[63:32]});
        check_lines(tag);
    endtask

    task automatic wr_time(input bit hi, input logic [31:0] d, input logic [3:0] s);
        logic [31:0] rd;
        logic er;
        bus(1'b1, hi ? 20'h0BFFC : 20'h0BFF8, d, s, rd, er);
        chk("R5 time write err", 64'(er), 64'd0);
        if (hi) m_time[63:32] = mrg(m_time[63:32], d, s);
        else    m_time[31:0]  = mrg(m_time[31:0], d, s);
        check_lines("R7 after time write");
    endtask

    task automatic wr_cmp(input int h, input bit hi, input logic [31:0] d, input logic [3:0] s);
        logic [31:0] rd;
        logic er;
        bus(1'b1, AW'(32'h4000 + 8 * h + (hi ? 4 : 0)), d, s, rd, er);
        chk("R4 cmp write err", 64'(er), 64'd0);
        if (hi) m_cmp[h][63:32] = mrg(m_cmp[h][63:32], d, s);
        else    m_cmp[h][31:0]  = mrg(m_cmp[h][31:0], d, s);
        check_lines("R7 after cmp write");
    endtask

    task automatic tick_n(input int n, input logic [SW-1:0] st);
        @(negedge clk);
        tick_en = 1'b1; tick_step = st;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
        m_time = m_time + 64'(n) * 64'(st);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin : main
        logic [31:0] rd;
        logic er;
        logic [AW-1:0] bad [10];
        m_time = '0;
        m_soft = '0;
        for (int h = 0; h < NH; h++) m_cmp[h] = '1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rsp_valid idle", 64'(rsp_valid), 64'd0);
        chk("R1 timer_irq", 64'(timer_irq), 64'd0);
        chk("R1 soft_irq", 64'(soft_irq), 64'd0);
        check_all("R1 reset");

        // R2/R3 software bit sweep over all byte-enable patterns
        for (int h = 0; h < NH; h++) begin
            for (int s = 0; s < 16; s++) begin
                for (int d = 0; d < 2; d++) begin
                    bus(1'b1, AW'(4 * h), 32'hFFFF_FFFE | 32'(d), 4'(s), rd, er);
                    chk("R3 soft write err", 64'(er), 64'd0);
                    if (s[0]) m_soft[h] = d[0];
                    chk("R3 soft_irq after write", 64'(soft_irq), 64'(m_soft));
                    bus(1'b0, AW'(4 * h), 32'h0, 4'h0, rd, er);
                    chk("R2 soft readback", {32'h0, rd}, {63'h0, m_soft[h]});
                end
            end
        end

        // R4/R5 byte-granular sweeps
        for (int s = 0; s < 16; s++) begin
            wr_time(1'b0, 32'hA1B2C3D4 ^ {4{8'(s * 17)}}, 4'(s));
            wr_time(1'b1, 32'h0F1E2D3C ^ {4{8'(s * 5)}}, 4'(s));
            for (int h = 0; h < NH; h++) begin
                wr_cmp(h, 1'b0, 32'h5566_7788 ^ {4{8'(s + h)}}, 4'(s));
                wr_cmp(h, 1'b1, 32'h1122_3344 ^ {4{8'(s * 3 + h)}}, 4'(s));
            end
            check_all("R4 R5 sweep");
        end

        // R6/R7/R8 equality boundary
        wr_cmp(1, 1'b0, 32'hFFFF_FFFF, 4'hF);
        wr_cmp(1, 1'b1, 32'hFFFF_FFFF, 4'hF);
        wr_cmp(0, 1'b1, 32'h0, 4'hF);
        wr_cmp(0, 1'b0, 32'd100, 4'hF);
        wr_time(1'b1, 32'h0, 4'hF);
        wr_time(1'b0, 32'd90, 4'hF);
        chk("R6 below cmp", 64'(timer_irq[0]), 64'd0);
        tick_n(1, 8'd5);
        chk("R8 one tick, R6 still below", 64'(timer_irq[0]), 64'd0);
        tick_n(1, 8'd5);
        chk("R6 equal asserts", 64'(timer_irq[0]), 64'd1);
        check_all("R8 after ticks");
        wr_cmp(0, 1'b0, 32'd101, 4'h1);
        chk("R7 raise cmp drops irq", 64'(timer_irq[0]), 64'd0);

        // R6 unsigned compare and R8 carry into the high word
        wr_cmp(1, 1'b1, 32'h8000_0000, 4'hF);
        wr_cmp(1, 1'b0, 32'h0, 4'hF);
        wr_time(1'b1, 32'h7FFF_FFFF, 4'hF);
        wr_time(1'b0, 32'hFFFF_FFFF, 4'hF);
        chk("R6 unsigned below", 64'(timer_irq[1]), 64'd0);
        tick_n(1, 8'd1);
        chk("R6 unsigned reach", 64'(timer_irq[1]), 64'd1);
        check_all("R8 carry");
        tick_n(50, 8'd3);
        check_all("R8 multi tick");

        // R9 write meets tick
        @(negedge clk);
        tick_en = 1'b1; tick_step = 8'd7;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h0BFF8;
        req_wdata = 32'h0000_1234; req_strb = 4'hF;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; tick_en = 1'b0;
        m_time[31:0] = 32'h0000_1234;
        check_all("R9 low write wins");
        @(negedge clk);
        tick_en = 1'b1; tick_step = 8'd9;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h0BFFC;
        req_wdata = 32'h0000_0002; req_strb = 4'h1;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; tick_en = 1'b0;
        m_time[63:32] = mrg(m_time[63:32], 32'h2, 4'h1);
        check_all("R9 high write wins");
        @(negedge clk);
        tick_en = 1'b1; tick_step = 8'd7;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h04000;
        req_wdata = 32'h0000_1240; req_strb = 4'hF;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; tick_en = 1'b0;
        m_cmp[0][31:0] = 32'h0000_1240;
        m_time = m_time + 64'd7;
        check_lines("R9 cmp write keeps tick");
        check_all("R9 cmp write keeps tick");

        // R10 declined accesses
        bad[0] = 20'h00008; bad[1] = 20'h00002; bad[2] = 20'h03FFC; bad[3] = 20'h04010;
        bad[4] = 20'h04006; bad[5] = 20'h0BFF4; bad[6] = 20'h0C000; bad[7] = 20'hC0000;
        bad[8] = 20'h1BFF8; bad[9] = 20'hFFFFC;
        for (int i = 0; i < 10; i++) begin
            bus(1'b1, bad[i], 32'hFFFF_FFFF, 4'hF, rd, er);
            chk("R10 write err", 64'(er), 64'd1);
            bus(1'b0, bad[i], 32'h0, 4'h0, rd, er);
            chk("R10 read err", 64'(er), 64'd1);
            chk("R10 read data zero", {32'h0, rd}, 64'h0);
            check_all("R10 no side effect");
        end

        done = 1;
        finish_run();
    end

endmodule